// File: doc/BRIEF.md
# Ethernet frame forwarding mode controller

This block moves Ethernet frames in one direction, from a byte-wide receive stream to a byte-wide transmit stream. Between the two sits a ring buffer whose space is counted in pages. A two-bit mode input chooses how a frame is passed on. Store-and-forward holds a frame until its last byte is stored. Modified cut-through starts sending once a minimum-frame's worth of bytes is stored. A direct converter mode wires receive to transmit with no buffering. A fourth setting behaves as the converter, but falls back to store-and-forward while a speed-mismatch input is high. Addresses and CRCs are never examined, so frames with bad CRCs are forwarded.

The receive side carries a valid strobe, a data byte and a last-byte marker. It has no ready signal, because a line receiver cannot be stalled. Instead, the block refuses a whole frame when the buffer cannot hold one of maximum length. The transmit side is valid/ready. While valid is high and ready is low, the byte and its flags are held unchanged. A byte leaves on each clock edge where both valid and ready are high. In converter mode the transmit stream is the receive stream in the same cycle, and ready is ignored.

In cut-through mode the block discards fragments. In every buffered mode it cuts a frame off at the maximum length and marks its end as errored. It also raises a buffer-full flag that an external pause generator can use. The mode must only change while no frame is being received and the buffer is empty.

Top module: `frame_fwd_ctrl`

## Requirements
- R1: Mode decode: 00 is store-and-forward, 01 is modified cut-through and 10 is converter. 11 acts as converter while `speed_mismatch` is low, and as store-and-forward while it is high.
- R2: In store-and-forward, `tx_valid` first rises in the cycle after the edge that stores the frame's last byte. The frame then leaves byte-exact, with `tx_last`=1 only on its final byte and `tx_err`=0. Frames of any length up to MAX_LEN are forwarded, fragments included.
- R3: In cut-through, `tx_valid` rises in the cycle after the edge that stores the MIN_FRAME-th byte, without waiting for the end of the frame. A frame shorter than MIN_FRAME that is kept starts after its last byte is stored.
- R4: In converter mode, `tx_valid`, `tx_data` and `tx_last` equal `rx_valid`, `rx_data` and `rx_last` in the same cycle, with `tx_err`=0. Frames longer than MAX_LEN pass whole, nothing is stored, and `buf_full` is 0.
- R5: In cut-through with `pass_frag`=0, a frame of FRAG_MIN to MIN_FRAME-1 bytes produces no output. With `pass_frag`=1, or for lengths below FRAG_MIN, the frame is forwarded whole.
- R6: In a buffered mode, a frame longer than MAX_LEN leaves as its first MAX_LEN bytes, and the last of them carries `tx_last`=1 and `tx_err`=1. Its remaining bytes are discarded.
- R7: In a buffered mode, `buf_full` is 1 exactly when fewer than ceil(MAX_LEN/page size) whole pages are free. A frame whose first byte arrives while `buf_full` is 1 is discarded entirely.
- R8: While `tx_valid`=1 and `tx_ready`=0, the transmit byte and flags stay stable. Buffered frames leave in arrival order under any ready pattern.
- R9: During reset, `tx_valid` and `buf_full` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Forwarding mode, encoded as in R1 |
| speed_mismatch | input | 1 | Port speeds differ; selects the fallback in mode 11 |
| pass_frag | input | 1 | Keep fragments in cut-through mode |
| rx_valid | input | 1 | Receive byte strobe |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Receive byte is the frame's last |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Transmit sink accepts the byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Transmit byte ends a frame |
| tx_err | output | 1 | Frame was truncated at MAX_LEN |
| buf_full | output | 1 | Buffer cannot admit another maximum-length frame |

## Verification
The bench builds the block with 8-byte pages, 12 pages, MAX_LEN 40, MIN_FRAME 16 and FRAG_MIN 8. With these values every frame length from 1 to 48 can be swept in all five mode settings, both with and without fragment passing. That sweep covers the fragment window edges, the cut-through start point and truncation beyond the maximum. With only 96 bytes of storage, a few held frames bring the free-page count to its admission threshold. The bench checks both sides of that boundary, together with the refusal of a frame that arrives when the buffer is full.

// File: rtl/frame_fwd_pkg.sv
package frame_fwd_pkg;
  typedef enum logic [1:0] {
    FWD_STORE     = 2'b00,
    FWD_CUT       = 2'b01,
    FWD_CONV      = 2'b10,
    FWD_CONV_AUTO = 2'b11
  } fwd_mode_e;

  typedef enum logic [1:0] {
    RX_IDLE = 2'b00,
    RX_TAKE = 2'b01,
    RX_SKIP = 2'b10
  } rx_state_e;

  typedef struct packed {
    logic       err;
    logic       last;
    logic [7:0] data;
  } fwd_word_t;
endpackage

// File: rtl/frame_fwd_mode_dec.sv
module frame_fwd_mode_dec
  import frame_fwd_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       speed_mismatch,
  output logic       conv,
  output logic       cut
);
  always_comb begin
    conv = 1'b0;
    cut  = 1'b0;
    case (fwd_mode_e'(mode))
      FWD_STORE:     ;
      FWD_CUT:       cut  = 1'b1;
      FWD_CONV:      conv = 1'b1;
      FWD_CONV_AUTO: conv = !speed_mismatch;
      default:       ;
    endcase
  end
endmodule

// File: rtl/frame_fwd_rx_admit.sv
module frame_fwd_rx_admit
  import frame_fwd_pkg::*;
#(
  parameter int MAX_LEN   = 1600,
  parameter int MIN_FRAME = 64,
  parameter int FRAG_MIN  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  input  logic rx_last,
  input  logic buffered,
  input  logic cut,
  input  logic pass_frag,
  input  logic space_ok,
  output logic wr_en,
  output logic wr_last,
  output logic wr_err,
  output logic rel,
  output logic drop
);
  localparam int CW = $clog2(MAX_LEN + 1);
  localparam logic [CW-1:0] L_MAX  = CW'(MAX_LEN);
  localparam logic [CW-1:0] L_MIN  = CW'(MIN_FRAME);
  localparam logic [CW-1:0] L_FRAG = CW'(FRAG_MIN);

  rx_state_e     st, st_n;
  logic [CW-1:0] cnt, cnt_n, n;

  always_comb begin
    wr_en   = 1'b0;
    wr_last = rx_last;
    wr_err  = 1'b0;
    rel     = 1'b0;
    drop    = 1'b0;
    st_n    = st;
    cnt_n   = cnt;
    n       = ((st == RX_IDLE) ? '0 : cnt) + 1'b1;
    if (rx_valid && buffered) begin
      if (st == RX_SKIP || (st == RX_IDLE && !space_ok)) begin
        st_n  = rx_last ? RX_IDLE : RX_SKIP;
        cnt_n = '0;
      end else if (cut && rx_last && !pass_frag && n >= L_FRAG && n < L_MIN) begin
        drop  = 1'b1;
        st_n  = RX_IDLE;
        cnt_n = '0;
      end else if (n == L_MAX && !rx_last) begin
        wr_en   = 1'b1;
        wr_last = 1'b1;
        wr_err  = 1'b1;
        rel     = 1'b1;
        st_n    = RX_SKIP;
        cnt_n   = '0;
      end else begin
        wr_en = 1'b1;
        rel   = rx_last || (cut && n >= L_MIN);
        st_n  = rx_last ? RX_IDLE : RX_TAKE;
        cnt_n = rx_last ? '0 : n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= RX_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end
endmodule

// File: rtl/frame_fwd_ring.sv
module frame_fwd_ring
  import frame_fwd_pkg::*;
#(
  parameter int PAGE_LOG = 6,
  parameter int PAGES    = 40,
  parameter int MAX_LEN  = 1600,
  localparam int DEPTH = PAGES << PAGE_LOG,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  fwd_word_t wr_word,
  input  logic      rel,
  input  logic      drop,
  input  logic      rd_en,
  output fwd_word_t rd_word,
  output logic      rd_avail,
  output logic      space_ok,
  output logic [CW-1:0] used_o,
  output logic [CW-1:0] ready_o
);
  localparam int FRAME_PAGES = (MAX_LEN + (1 << PAGE_LOG) - 1) >> PAGE_LOG;

  fwd_word_t     mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_n;
  logic [CW-1:0] used, ready, pending;
  logic [CW-1:0] used_n, ready_n, pending_n, free_b, free_pages;
  logic [CW:0]   rw;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rw = {1'b0, CW'(wptr)} + (CW+1)'(DEPTH) - {1'b0, pending};
    if (rw >= (CW+1)'(DEPTH)) rw = rw - (CW+1)'(DEPTH);
    wptr_n = wr_en ? adv(wptr) : (drop ? AW'(rw) : wptr);
    used_n = used + CW'(wr_en) - CW'(rd_en) - (drop ? pending : '0);
    ready_n = ready - CW'(rd_en) + ((wr_en && rel) ? pending + 1'b1 : '0);
    pending_n = drop ? '0 : (wr_en ? (rel ? '0 : pending + 1'b1) : pending);
    free_b = CW'(DEPTH) - used;
    free_pages = free_b >> PAGE_LOG;
  end

  assign space_ok = free_pages >= CW'(FRAME_PAGES);
  assign rd_avail = ready != '0;
  assign rd_word  = mem[rptr];
  assign used_o   = used;
  assign ready_o  = ready;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      used    <= '0;
      ready   <= '0;
      pending <= '0;
    end else begin
      wptr    <= wptr_n;
      if (rd_en) rptr <= adv(rptr);
      used    <= used_n;
      ready   <= ready_n;
      pending <= pending_n;
    end
  end
endmodule

// File: rtl/frame_fwd_ctrl.sv
module frame_fwd_ctrl
  import frame_fwd_pkg::*;
#(
  parameter int PAGE_LOG  = 6,
  parameter int PAGES     = 40,
  parameter int MAX_LEN   = 1600,
  parameter int MIN_FRAME = 64,
  parameter int FRAG_MIN  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       speed_mismatch,
  input  logic       pass_frag,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_last,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  output logic       tx_last,
  output logic       tx_err,
  output logic       buf_full
);
  localparam int DEPTH = PAGES << PAGE_LOG;
  localparam int CW    = $clog2(DEPTH + 1);

  logic      conv_w, cut_w, wr_en_w, wr_last_w, wr_err_w, rel_w, drop_w;
  logic      rd_en_w, rd_avail_w, space_ok_w;
  fwd_word_t wr_word_w, rd_word_w;
  logic [CW-1:0] used_w, ready_w;

  frame_fwd_mode_dec u_dec (
    .mode(mode), .speed_mismatch(speed_mismatch), .conv(conv_w), .cut(cut_w)
  );

  frame_fwd_rx_admit #(
    .MAX_LEN(MAX_LEN), .MIN_FRAME(MIN_FRAME), .FRAG_MIN(FRAG_MIN)
  ) u_admit (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_last(rx_last),
    .buffered(!conv_w), .cut(cut_w), .pass_frag(pass_frag),
    .space_ok(space_ok_w), .wr_en(wr_en_w), .wr_last(wr_last_w),
    .wr_err(wr_err_w), .rel(rel_w), .drop(drop_w)
  );

  assign wr_word_w = '{err: wr_err_w, last: wr_last_w, data: rx_data};
  assign rd_en_w   = !conv_w && rd_avail_w && tx_ready;

  frame_fwd_ring #(
    .PAGE_LOG(PAGE_LOG), .PAGES(PAGES), .MAX_LEN(MAX_LEN)
  ) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_w), .wr_word(wr_word_w),
    .rel(rel_w), .drop(drop_w), .rd_en(rd_en_w), .rd_word(rd_word_w),
    .rd_avail(rd_avail_w), .space_ok(space_ok_w), .used_o(used_w),
    .ready_o(ready_w)
  );

  always_comb begin
    if (conv_w) begin
      tx_valid = rx_valid;
      tx_data  = rx_data;
      tx_last  = rx_last;
      tx_err   = 1'b0;
    end else begin
      tx_valid = rd_avail_w;
      tx_data  = rd_word_w.data;
      tx_last  = rd_word_w.last;
      tx_err   = rd_word_w.err;
    end
  end

  assign buf_full = !conv_w && !space_ok_w;
endmodule

// File: rtl/frame_fwd_chk.sv
module frame_fwd_chk #(
  parameter int CW    = 12,
  parameter int DEPTH = 2560
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv,
  input logic          wr_en,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          tx_err,
  input logic          buf_full,
  input logic [CW-1:0] used,
  input logic [CW-1:0] ready
);
  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !conv) |=>
      (conv || (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_err))));

  assert_conv_no_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv |-> !wr_en);

  assert_trunc_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_err) |-> tx_last);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    used <= CW'(DEPTH));

  assert_full_buffered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !conv);

  assert_ready_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready <= used);
endmodule

bind frame_fwd_ctrl frame_fwd_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv(conv_w), .wr_en(wr_en_w),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_last(tx_last), .tx_err(tx_err), .buf_full(buf_full),
  .used(used_w), .ready(ready_w)
);

// File: tb/frame_fwd_ctrl_bench.sv
module frame_fwd_ctrl_bench;
  localparam int PL = 3, PG = 12, ML = 40, MF = 16, FM = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic speed_mismatch = 1'b0, pass_frag = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0, tx_ready = 1'b1;
  logic [7:0] rx_data = 8'h00;
  logic tx_valid, tx_last, tx_err, buf_full;
  logic [7:0] tx_data;

  always #2 clk = ~clk;

  frame_fwd_ctrl #(.PAGE_LOG(PL), .PAGES(PG), .MAX_LEN(ML),
                   .MIN_FRAME(MF), .FRAG_MIN(FM)) u_frame_fwd_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .speed_mismatch(speed_mismatch),
    .pass_frag(pass_frag), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_err(tx_err), .buf_full(buf_full)
  );

  int cyc = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] cd [256];
  logic       cl [256], ce [256];
  logic [7:0] ed [256];
  logic       el [256], ee [256];
  int cn = 0, en = 0, cfirst = -1;

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (cn == 0) cfirst = cyc;
      if (cn < 256) begin
        cd[cn] = tx_data; cl[cn] = tx_last; ce[cn] = tx_err;
      end
      cn++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_cap();
    cn = 0; en = 0; cfirst = -1;
  endtask

  task automatic expect_frame(input int len, input int base, input bit conv,
                              input bit cut, input bit pass, output int n);
    if (conv) n = len;
    else if (cut && !pass && len >= FM && len < MF) n = 0;
    else n = (len > ML) ? ML : len;
    for (int i = 0; i < n; i++) begin
      ed[en] = 8'(base + i);
      el[en] = (i == n - 1);
      ee[en] = (i == n - 1) && !conv && (len > ML);
      en++;
    end
  endtask

  task automatic send(input int len, input int base, output int dfirst);
    dfirst = 0;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_data = 8'(base + i); rx_last = (i == len - 1);
      if (i == 0) dfirst = cyc;
    end
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic compare(input string tag);
    int bad;
    bad = -1;
    chk(cn == en, {tag, " byte count"}, cn, en);
    for (int i = 0; i < en && i < cn; i++)
      if (bad < 0 && (cd[i] != ed[i] || cl[i] != el[i] || ce[i] != ee[i])) bad = i;
    if (bad >= 0)
      chk(1'b0, {tag, " content {err,last,data}"},
          int'({ce[bad], cl[bad], cd[bad]}), int'({ee[bad], el[bad], ed[bad]}));
    else chk(1'b1, tag, 0, 0);
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int d, n, nrel, b0;
    bit conv, cut;
    string tg;
    repeat (3) @(posedge clk);
    #1;
    chk(tx_valid == 1'b0, "R9 tx_valid in reset", int'(tx_valid), 0);
    chk(buf_full == 1'b0, "R9 buf_full in reset", int'(buf_full), 0);
    rst_n = 1'b1;
    wait_cyc(2);

    // Sweep of all mode settings, fragment passing and frame lengths
    for (int m = 0; m < 5; m++) begin
      case (m)
        0: begin mode = 2'b00; speed_mismatch = 1'b0; conv = 0; cut = 0; end
        1: begin mode = 2'b01; speed_mismatch = 1'b0; conv = 0; cut = 1; end
        2: begin mode = 2'b10; speed_mismatch = 1'b0; conv = 1; cut = 0; end
        3: begin mode = 2'b11; speed_mismatch = 1'b0; conv = 1; cut = 0; end
        default: begin mode = 2'b11; speed_mismatch = 1'b1; conv = 0; cut = 0; end
      endcase
      for (int p = 0; p < 2; p++) begin
        pass_frag = p[0];
        for (int len = 1; len <= 48; len++) begin
          if (!conv && len > ML) tg = "R6";
          else if (cut && len >= FM && len < MF) tg = "R5";
          else if (m == 0) tg = "R2";
          else if (m == 1) tg = "R3";
          else if (m == 2) tg = "R4";
          else tg = "R1";
          clear_cap();
          b0 = (len * 7 + m * 31 + p * 5) & 255;
          expect_frame(len, b0, conv, cut, p[0], n);
          send(len, b0, d);
          wait_cyc(len + 8);
          compare(tg);
          if (n > 0) begin
            if (conv) nrel = 0;
            else if (cut) nrel = (len < MF) ? len : MF;
            else nrel = (len > ML) ? ML : len;
            chk(cfirst == d + nrel, {tg, " start cycle"}, cfirst, d + nrel);
          end
          if (conv) chk(buf_full == 1'b0, "R4 buf_full", int'(buf_full), 0);
          chk(tx_valid == 1'b0, {tg, " drained"}, int'(tx_valid), 0);
        end
      end
    end
    pass_frag = 1'b0; speed_mismatch = 1'b0; mode = 2'b00;

    // Back-pressure and ordering
    tx_ready = 1'b0;
    clear_cap();
    expect_frame(10, 100, 0, 0, 0, n); send(10, 100, d);
    expect_frame(12, 120, 0, 0, 0, n); send(12, 120, d);
    expect_frame(9, 140, 0, 0, 0, n);  send(9, 140, d);
    chk(tx_valid == 1'b1 && tx_data == 8'd100, "R8 held byte", int'(tx_data), 100);
    wait_cyc(3);
    chk(tx_valid == 1'b1 && tx_data == 8'd100, "R8 held byte stable", int'(tx_data), 100);
    for (int k = 0; k < 90; k++) begin
      @(posedge clk); #1;
      tx_ready = k[0];
    end
    tx_ready = 1'b1;
    wait_cyc(8);
    compare("R8 order");

    // Admission and full flag at the page boundary
    tx_ready = 1'b0;
    clear_cap();
    expect_frame(30, 0, 0, 0, 0, n); send(30, 0, d);
    chk(buf_full == 1'b0, "R7 8 pages free", int'(buf_full), 0);
    expect_frame(26, 50, 0, 0, 0, n); send(26, 50, d);
    chk(buf_full == 1'b0, "R7 5 pages free", int'(buf_full), 0);
    expect_frame(1, 90, 0, 0, 0, n); send(1, 90, d);
    chk(buf_full == 1'b1, "R7 4 pages free", int'(buf_full), 1);
    send(5, 200, d);
    chk(buf_full == 1'b1, "R7 refused frame", int'(buf_full), 1);
    tx_ready = 1'b1;
    wait_cyc(80);
    compare("R7 admission");
    chk(buf_full == 1'b0, "R7 after drain", int'(buf_full), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule